// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block turns one vector add into a series of per-element register requests. A start strobe captures three base register numbers, one scalar/vector flag for each operand, and the vector length and maximum vector length from the state register. The sequencer then presents one set of destination and source register indices per element with a valid strobe. It advances only when the downstream ALU takes the current element on a valid/ready handshake.

An operand flagged as vector steps its register number by one for each element, and the index wraps within a 32-entry register file. A scalar operand keeps its base number for the whole loop. A scalar destination ends the loop after its first element. The loop runs for the smaller of the two length fields. A zero count issues nothing. At the end of the loop a single-cycle done pulse is raised and the block returns to idle.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, and while idle, elem_valid_o and done_o are low.
- R2: When the destination is vector, the number of elements accepted equals min(vl_i, maxvl_i), with both fields sampled at the start strobe.
- R3: A vector operand's index for element n (counting from 0) is (base + n) mod 32.
- R4: A scalar source operand presents its base register number for every element.
- R5: A scalar destination gives exactly one element when the effective count is nonzero, whatever vl_i is.
- R6: A zero effective count issues no element, and done_o is high in the cycle after the start strobe.
- R7: While elem_valid_o is high and elem_ready_i is low, the valid strobe and all three indices hold steady.
- R8: done_o is high for exactly one cycle, starting in the cycle after the last element is accepted. It never coincides with elem_valid_o, and the block is idle afterwards.
- R9: A start strobe received while a loop is in progress is ignored: the indices and the element count are not disturbed.
- R10: An index that steps past 31 wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a loop; only taken while idle |
| dst_base_i | input | 5 | Destination base register number |
| srca_base_i | input | 5 | Source A base register number |
| srcb_base_i | input | 5 | Source B base register number |
| dst_vec_i | input | 1 | 1 = destination is vector, 0 = scalar |
| srca_vec_i | input | 1 | 1 = source A is vector, 0 = scalar |
| srcb_vec_i | input | 1 | 1 = source B is vector, 0 = scalar |
| vl_i | input | 7 | Vector length field |
| maxvl_i | input | 7 | Maximum vector length field |
| elem_ready_i | input | 1 | ALU accepts the current element |
| elem_valid_o | output | 1 | Element indices are valid |
| dst_idx_o | output | 5 | Destination register index |
| srca_idx_o | output | 5 | Source A register index |
| srcb_idx_o | output | 5 | Source B register index |
| done_o | output | 1 | One-cycle end-of-loop pulse |

## Verification
The assertions assume that elem_ready_i is only meaningful while elem_valid_o is high. They also assume that the operand flags and length fields matter only in the cycle where start_i is taken, so the checker keeps its own copy of the flags captured at that point. The stimulus changes every input only at the falling edge and drops start_i after one cycle, except in the test that deliberately repeats it mid-loop. Ready patterns cover both continuous acceptance and alternating stalls, so the hold property is exercised on every stalled element.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int unsigned REG_AW_DEF = 5;
  localparam int unsigned VL_W_DEF   = 7;
  localparam int unsigned N_OPS      = 3;  // dst, src a, src b

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vseq_len_calc.sv
module vseq_len_calc #(
  parameter int unsigned VL_W = vseq_pkg::VL_W_DEF
) (
  input  logic [VL_W-1:0] vl_i,
  input  logic [VL_W-1:0] maxvl_i,
  input  logic            dst_vec_i,
  output logic [VL_W-1:0] count_o
);
  logic [VL_W-1:0] clamp;

  always_comb begin
    clamp = (vl_i < maxvl_i) ? vl_i : maxvl_i;
    // scalar destination: a single element at most
    if (!dst_vec_i && clamp != '0) count_o = VL_W'(1);
    else                           count_o = clamp;
  end
endmodule

// File: rtl/vseq_elem_ctr.sv
module vseq_elem_ctr #(
  parameter int unsigned VL_W = vseq_pkg::VL_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            step_i,
  input  logic [VL_W-1:0] total_i,
  output logic [VL_W-1:0] elem_o,
  output logic            last_o
);
  logic [VL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + VL_W'(1);
  end

  assign elem_o = cnt_q;
  assign last_o = (cnt_q == total_i - VL_W'(1));
endmodule

// File: rtl/vseq_idx_step.sv
module vseq_idx_step #(
  parameter int unsigned REG_AW = vseq_pkg::REG_AW_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [REG_AW-1:0] base_i,
  input  logic              vec_i,
  input  logic [REG_AW-1:0] elem_i,
  output logic [REG_AW-1:0] idx_o
);
  logic [REG_AW-1:0] base_q;
  logic              vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      vec_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= base_i;
      vec_q  <= vec_i;
    end
  end

  // modulo 2**REG_AW by truncation
  assign idx_o = vec_q ? (base_q + elem_i) : base_q;
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int unsigned REG_AW = vseq_pkg::REG_AW_DEF,
  parameter int unsigned VL_W   = vseq_pkg::VL_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REG_AW-1:0] dst_base_i,
  input  logic [REG_AW-1:0] srca_base_i,
  input  logic [REG_AW-1:0] srcb_base_i,
  input  logic              dst_vec_i,
  input  logic              srca_vec_i,
  input  logic              srcb_vec_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [VL_W-1:0]   maxvl_i,
  input  logic              elem_ready_i,
  output logic              elem_valid_o,
  output logic [REG_AW-1:0] dst_idx_o,
  output logic [REG_AW-1:0] srca_idx_o,
  output logic [REG_AW-1:0] srcb_idx_o,
  output logic              done_o
);
  import vseq_pkg::*;

  seq_state_e state_q;
  logic [VL_W-1:0] total_q, count_in, elem;
  logic seq_idle, load, accept, last;

  logic [N_OPS-1:0][REG_AW-1:0] base_all, idx_all;
  logic [N_OPS-1:0]             vec_all;

  assign seq_idle = (state_q == ST_IDLE);
  assign load     = seq_idle && start_i;
  assign accept   = elem_valid_o && elem_ready_i;

  vseq_len_calc #(.VL_W(VL_W)) u_len (
    .vl_i     (vl_i),
    .maxvl_i  (maxvl_i),
    .dst_vec_i(dst_vec_i),
    .count_o  (count_in)
  );

  vseq_elem_ctr #(.VL_W(VL_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load),
    .step_i (accept),
    .total_i(total_q),
    .elem_o (elem),
    .last_o (last)
  );

  assign base_all = {srcb_base_i, srca_base_i, dst_base_i};
  assign vec_all  = {srcb_vec_i, srca_vec_i, dst_vec_i};

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    vseq_idx_step #(.REG_AW(REG_AW)) u_step (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load),
      .base_i(base_all[g]),
      .vec_i (vec_all[g]),
      .elem_i(elem[REG_AW-1:0]),
      .idx_o (idx_all[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      total_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          total_q <= count_in;
          state_q <= (count_in == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN:  if (accept && last) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign elem_valid_o = (state_q == ST_RUN);
  assign done_o       = (state_q == ST_DONE);
  assign dst_idx_o    = idx_all[0];
  assign srca_idx_o   = idx_all[1];
  assign srcb_idx_o   = idx_all[2];
endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned VL_W   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              seq_idle,
  input logic              dst_vec_i,
  input logic              srca_vec_i,
  input logic [VL_W-1:0]   vl_i,
  input logic [VL_W-1:0]   maxvl_i,
  input logic              elem_ready_i,
  input logic              elem_valid_o,
  input logic [REG_AW-1:0] dst_idx_o,
  input logic [REG_AW-1:0] srca_idx_o,
  input logic [REG_AW-1:0] srcb_idx_o,
  input logic              done_o
);
  logic dst_scalar_q, srca_scalar_q;
  logic take, zero_len;

  assign take     = seq_idle && start_i;
  assign zero_len = (vl_i == '0) || (maxvl_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_scalar_q  <= 1'b0;
      srca_scalar_q <= 1'b0;
    end else if (take) begin
      dst_scalar_q  <= !dst_vec_i;
      srca_scalar_q <= !srca_vec_i;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_idle |-> !elem_valid_o);

  a_r3_vec_dst_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_valid_o && elem_ready_i && !dst_scalar_q) |=>
      (!elem_valid_o || dst_idx_o == REG_AW'($past(dst_idx_o) + 1'b1)));

  a_r4_scalar_src_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_valid_o && elem_ready_i && srca_scalar_q) |=>
      (!elem_valid_o || $stable(srca_idx_o)));

  a_r5_scalar_dst_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_valid_o && elem_ready_i && dst_scalar_q) |=> done_o);

  a_r6_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && zero_len) |=> (done_o && !elem_valid_o));

  a_r7_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elem_valid_o && !elem_ready_i) |=>
      (elem_valid_o && $stable(dst_idx_o) && $stable(srca_idx_o) && $stable(srcb_idx_o)));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && seq_idle));

  a_r8_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && elem_valid_o));
endmodule

bind vec_elem_seq vec_elem_seq_chk #(.REG_AW(REG_AW), .VL_W(VL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .seq_idle    (seq_idle),
  .dst_vec_i   (dst_vec_i),
  .srca_vec_i  (srca_vec_i),
  .vl_i        (vl_i),
  .maxvl_i     (maxvl_i),
  .elem_ready_i(elem_ready_i),
  .elem_valid_o(elem_valid_o),
  .dst_idx_o   (dst_idx_o),
  .srca_idx_o  (srca_idx_o),
  .srcb_idx_o  (srcb_idx_o),
  .done_o      (done_o)
);

// File: tb/vec_elem_seq_bench.sv
module vec_elem_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 9;
  localparam int WDOG_MAX   = 20000;

  // fields: dst a b (5 each), dv av bv, vl(7), maxvl(7), stall(1) = 33 bits
  localparam logic [32:0] VEC [N_VEC] = '{
    {5'd1,  5'd5,  5'd9,  3'b111, 7'd2, 7'd2, 1'b0},  // both vector
    {5'd1,  5'd5,  5'd9,  3'b011, 7'd2, 7'd2, 1'b0},  // scalar dst
    {5'd1,  5'd5,  5'd9,  3'b101, 7'd2, 7'd2, 1'b0},  // scalar src a
    {5'd3,  5'd7,  5'd11, 3'b111, 7'd5, 7'd3, 1'b1},  // clamp to maxvl
    {5'd30, 5'd31, 5'd0,  3'b111, 7'd4, 7'd8, 1'b1},  // wrap
    {5'd4,  5'd4,  5'd4,  3'b111, 7'd0, 7'd4, 1'b0},  // zero vl
    {5'd4,  5'd4,  5'd4,  3'b011, 7'd3, 7'd0, 1'b0},  // zero maxvl
    {5'd20, 5'd2,  5'd28, 3'b110, 7'd7, 7'd9, 1'b1},  // scalar src b
    {5'd9,  5'd9,  5'd9,  3'b001, 7'd90,7'd90,1'b1}   // scalar dst, big vl
  };

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0, ready = 1'b0;
  logic [4:0] dst_b = '0, a_b = '0, b_b = '0;
  logic dv = 1'b0, av = 1'b0, bv = 1'b0;
  logic [6:0] vl = '0, mvl = '0;
  logic valid, done;
  logic [4:0] dst_idx, a_idx, b_idx;

  int n_chk = 0, n_bad = 0, wdog = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_elem_seq u_vec_elem_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .dst_base_i(dst_b), .srca_base_i(a_b), .srcb_base_i(b_b),
    .dst_vec_i(dv), .srca_vec_i(av), .srcb_vec_i(bv),
    .vl_i(vl), .maxvl_i(mvl), .elem_ready_i(ready),
    .elem_valid_o(valid), .dst_idx_o(dst_idx), .srca_idx_o(a_idx),
    .srcb_idx_o(b_idx), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int step_idx(input int base, input logic vec, input int n);
    return vec ? ((base + n) % 32) : base;
  endfunction

  task automatic run_loop(input logic [32:0] v);
    int exp_n, n, cyc;
    logic stall;
    bit saw_done;
    {dst_b, a_b, b_b, dv, av, bv, vl, mvl, stall} = v;
    exp_n = (vl < mvl) ? vl : mvl;
    if (!dv && exp_n > 0) exp_n = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; cyc = 0; saw_done = 0;
    while (cyc < 400) begin
      if (done) begin saw_done = 1; break; end
      if (valid) begin
        chk(dv ? "R3 dst idx" : "R5 dst idx", dst_idx, step_idx(dst_b, dv, n));
        chk(av ? "R3 srca idx" : "R4 srca idx", a_idx, step_idx(a_b, av, n));
        chk(bv ? "R10 srcb idx" : "R4 srcb idx", b_idx, step_idx(b_b, bv, n));
      end
      ready = stall ? cyc[0] : 1'b1;
      if (valid && ready) n++;
      cyc++;
      @(negedge clk);
    end
    ready = 1'b0;
    chk(dv ? "R2 element count" : "R5 element count", n, exp_n);
    chk("R8 done seen", int'(saw_done), 1);
    if (exp_n == 0) chk("R6 done right after start", cyc, 0);
    chk("R8 no valid with done", int'(valid), 0);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    chk("R8 idle after done", int'(valid), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wdog++;
      if (wdog > WDOG_MAX) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <= %0d", wdog, WDOG_MAX);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(valid), 0);
    chk("R1 reset done", int'(done), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", int'(valid), 0);

    for (int i = 0; i < N_VEC; i++) run_loop(VEC[i]);

    // R7 and R9: stall, then a second start mid-loop
    {dst_b, a_b, b_b} = {5'd10, 5'd12, 5'd14};
    {dv, av, bv} = 3'b111; vl = 7'd3; mvl = 7'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ready = 1'b1;  // accept element 0
    @(negedge clk);
    ready = 1'b0;
    chk("R3 second elem dst", dst_idx, 11);
    repeat (3) @(negedge clk);
    chk("R7 hold valid", int'(valid), 1);
    chk("R7 hold dst", dst_idx, 11);
    {dst_b, a_b, b_b} = {5'd0, 5'd0, 5'd0};
    vl = 7'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 dst after restart", dst_idx, 11);
    chk("R9 srcb after restart", b_idx, 15);
    ready = 1'b1;
    @(negedge clk);
    chk("R9 loop continues", dst_idx, 12);
    chk("R9 still valid", int'(valid), 1);
    @(negedge clk);
    ready = 1'b0;
    chk("R8 done after third", int'(done), 1);
    @(negedge clk);
    chk("R8 done cleared", int'(done), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule